// File: doc/BRIEF.md
# Asynchronous Compute Group Tracker

This block keeps count of batches of asynchronous compute operations that read operands from a ring of buffer slots. The requester opens a group, issues one or more operations into it, and then commits it. Each committed group counts as outstanding until the modelled execution unit sends one completion pulse for it. Completions always retire the oldest group first.

A requester that wants to reuse results or slots raises a wait request with a threshold. The request is granted only while the number of outstanding groups is at or below that threshold. A threshold of 1 lets the group just committed keep running while guaranteeing that the one before it has finished. A threshold of 0 drains everything.

Slot release runs one group behind issue. A retired group's slot is announced only once a later wait has been granted, so compute on slot k overlaps the loading of slot k+1. The block also tells the datapath whether each accepted operation overwrites or accumulates into the accumulator, and it raises sticky flags for counter overflow and protocol misuse.

Top module: `async_group_tracker`

## Requirements
- R1: An issue is accepted (`issue_go_o` high in the same cycle) only while a group is open. A fence opens a group. An accepted commit closes it, so an issue after a commit and before the next fence is refused.
- R2: `out_cnt_o` rises by one in the cycle after each accepted commit and falls by one in the cycle after each completion pulse. It is unchanged when neither happens, or when both happen in the same cycle.
- R3: `wait_go_o` is high in a cycle exactly when `wait_i` is high and `out_cnt_o` is less than or equal to `wait_thr_i`. Otherwise the requester is stalled.
- R4: Committed groups are numbered from 0 in commit order, and a group's slot index is its number modulo STAGES. A granted wait authorises the release of every group retired before that cycle. Each authorised release appears as a one-cycle `rel_valid_o` pulse with `rel_slot_o`, starting in the cycle after the grant.
- R5: In a loop that commits group k, receives the completion of group k-1, and then waits with threshold 1, the slot of group k-1 is released right after iteration k's wait. No release follows iteration 0's wait.
- R6: After the final iteration, a wait with threshold 0 is granted only once every group has retired. All remaining slots are then released in commit order, one per consecutive cycle.
- R7: The first issue accepted after reset, or after a granted wait with threshold 0, has `issue_accum_o` low (overwrite). Every other accepted issue has it high (accumulate).
- R8: The outstanding count saturates at 2^OW-1. A commit at that level with no completion in the same cycle leaves the count unchanged and sets the sticky `ovf_err_o`.
- R9: An issue or commit while no group is open, or a completion pulse while nothing is outstanding, sets the sticky `proto_err_o`. Such a completion leaves the count at zero.
- R10: After reset, `out_cnt_o` is 0, and `rel_valid_o`, `ovf_err_o`, `proto_err_o` and `issue_go_o` are low.
- R11: Slot indices wrap from STAGES-1 back to 0 as groups continue to be committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fence_i | input | 1 | Open a new group |
| issue_i | input | 1 | Issue one operation into the open group |
| commit_i | input | 1 | Close the open group and count it as outstanding |
| wait_i | input | 1 | Wait request |
| wait_thr_i | input | OW | Highest outstanding count that lets the wait through |
| done_i | input | 1 | Completion pulse from the execution unit, retires the oldest group |
| issue_go_o | output | 1 | Issue accepted this cycle |
| issue_accum_o | output | 1 | Accepted issue accumulates (0 means overwrite) |
| wait_go_o | output | 1 | Wait granted this cycle |
| out_cnt_o | output | OW | Number of committed groups still in flight |
| rel_valid_o | output | 1 | Slot release pulse |
| rel_slot_o | output | SW | Index of the released slot |
| ovf_err_o | output | 1 | Sticky outstanding-counter overflow |
| proto_err_o | output | 1 | Sticky protocol error |

## Verification
The bench runs a staggered loop long enough to wrap the slot ring. A design that releases a slot when the group retires, rather than at the next grant, would produce a release the scoreboard does not expect. A release lagging by the wrong number of groups would show up as a slot mismatch. Each wait is probed once before the completion that should unblock it, so a design comparing with less-than instead of less-or-equal grants or stalls at the wrong count.

The drain phase retires three groups and then waits with threshold 0. A design that releases only one slot per grant, or releases out of order, leaves the queue non-empty or mismatched. Saturation is driven one commit past the maximum, which catches a counter that wraps to zero. Refused issues and spurious completions are checked at the ports for both the flag and an unchanged count.

// File: rtl/agt_pkg.sv
package agt_pkg;

    // Width of an index into a ring of n entries (at least one bit).
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/agt_outstanding.sv
module agt_outstanding #(
    parameter int OW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit_ok,
    input  logic          done,
    output logic [OW-1:0] cnt_o,
    output logic          retire_o,
    output logic          ovf_o
);
    localparam logic [OW-1:0] CNT_MAX = {OW{1'b1}};

    typedef struct packed {
        logic [OW-1:0] cnt;
        logic          ovf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    retire;

    always_comb begin
        st_d   = st_q;
        retire = done && (st_q.cnt != '0);
        if (commit_ok && !retire) begin
            if (st_q.cnt == CNT_MAX) st_d.ovf = 1'b1;
            else                     st_d.cnt = st_q.cnt + 1'b1;
        end else if (!commit_ok && retire) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o    = st_q.cnt;
    assign retire_o = retire;
    assign ovf_o    = st_q.ovf;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ok && !done && cnt_o == CNT_MAX) |=> (ovf_o && cnt_o == CNT_MAX)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o); // R8
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_ok && !done) |=> $stable(cnt_o)); // R2
    AST_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !commit_ok && cnt_o == '0) |=> (cnt_o == '0)); // R9

endmodule

// File: rtl/agt_release.sv
module agt_release #(
    parameter int STAGES = 4,
    parameter int PW     = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               retire,
    input  logic                               grant,
    output logic                               rel_valid_o,
    output logic [agt_pkg::idx_width(STAGES)-1:0] rel_slot_o
);
    localparam int SW = agt_pkg::idx_width(STAGES);
    localparam logic [SW-1:0] SLOT_LAST = SW'(STAGES - 1);

    typedef struct packed {
        logic [PW-1:0] unauth;  // retired, not yet covered by a grant
        logic [PW-1:0] pend;    // authorised, not yet released
        logic [SW-1:0] slot;    // slot of the next release
    } rel_st_t;

    rel_st_t st_d, st_q;
    logic    rel;

    always_comb begin
        st_d        = st_q;
        rel         = (st_q.pend != '0);
        st_d.unauth = (grant ? '0 : st_q.unauth) + PW'(retire);
        st_d.pend   = st_q.pend - PW'(rel) + (grant ? st_q.unauth : '0);
        if (rel) st_d.slot = (st_q.slot == SLOT_LAST) ? '0 : st_q.slot + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rel_valid_o = rel;
    assign rel_slot_o  = st_q.slot;

    AST_REL_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_valid_o) |-> $past(grant)); // R4
    AST_REL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid_o |=> (!rel_valid_o ||
            rel_slot_o == (($past(rel_slot_o) == SLOT_LAST) ? '0 : $past(rel_slot_o) + 1'b1))); // R11

endmodule

// File: rtl/async_group_tracker.sv
module async_group_tracker #(
    parameter int STAGES = 4,
    parameter int OW     = 4,
    localparam int SW    = agt_pkg::idx_width(STAGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fence_i,
    input  logic          issue_i,
    input  logic          commit_i,
    input  logic          wait_i,
    input  logic [OW-1:0] wait_thr_i,
    input  logic          done_i,
    output logic          issue_go_o,
    output logic          issue_accum_o,
    output logic          wait_go_o,
    output logic [OW-1:0] out_cnt_o,
    output logic          rel_valid_o,
    output logic [SW-1:0] rel_slot_o,
    output logic          ovf_err_o,
    output logic          proto_err_o
);
    localparam int PW = OW + 2;

    typedef struct packed {
        logic open;
        logic first;
        logic perr;
    } top_st_t;

    top_st_t       st_d, st_q;
    logic          issue_ok, commit_ok, grant, rearm, retire;
    logic [OW-1:0] cnt;

    always_comb begin
        st_d      = st_q;
        issue_ok  = issue_i && st_q.open;
        commit_ok = commit_i && st_q.open;
        grant     = wait_i && (cnt <= wait_thr_i);
        rearm     = grant && (wait_thr_i == '0);
        if (commit_ok)    st_d.open = 1'b0;
        else if (fence_i) st_d.open = 1'b1;
        if (rearm)         st_d.first = 1'b1;
        else if (issue_ok) st_d.first = 1'b0;
        if ((issue_i && !st_q.open) || (commit_i && !st_q.open) || (done_i && cnt == '0))
            st_d.perr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{open: 1'b0, first: 1'b1, perr: 1'b0};
        else        st_q <= st_d;
    end

    agt_outstanding #(.OW(OW)) u_outstanding (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_ok (commit_ok),
        .done      (done_i),
        .cnt_o     (cnt),
        .retire_o  (retire),
        .ovf_o     (ovf_err_o)
    );

    agt_release #(.STAGES(STAGES), .PW(PW)) u_release (
        .clk         (clk),
        .rst_n       (rst_n),
        .retire      (retire),
        .grant       (grant),
        .rel_valid_o (rel_valid_o),
        .rel_slot_o  (rel_slot_o)
    );

    assign issue_go_o    = issue_ok;
    assign issue_accum_o = issue_ok && !st_q.first;
    assign wait_go_o     = grant;
    assign out_cnt_o     = cnt;
    assign proto_err_o   = st_q.perr;

    AST_CLOSED_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && issue_go_o && !fence_i) |=> !issue_go_o); // R1
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o); // R9
    AST_FIRST_OVERWRITES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wait_go_o && wait_thr_i == '0) && issue_go_o) |-> !issue_accum_o); // R7
    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_go_o && wait_thr_i == '0) |-> (out_cnt_o == '0)); // R6

endmodule

// File: tb/test_async_group_tracker.sv
`timescale 1ns/1ps
module test_async_group_tracker;
    localparam int STAGES = 4;
    localparam int OW     = 4;
    localparam int SW     = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fence_i = 0, issue_i = 0, commit_i = 0, wait_i = 0, done_i = 0;
    logic [OW-1:0] wait_thr_i = '0;
    logic          issue_go_o, issue_accum_o, wait_go_o, rel_valid_o, ovf_err_o, proto_err_o;
    logic [OW-1:0] out_cnt_o;
    logic [SW-1:0] rel_slot_o;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];

    always #2 clk = ~clk;

    async_group_tracker #(.STAGES(STAGES), .OW(OW)) i_async_group_tracker (
        .clk(clk), .rst_n(rst_n), .fence_i(fence_i), .issue_i(issue_i),
        .commit_i(commit_i), .wait_i(wait_i), .wait_thr_i(wait_thr_i), .done_i(done_i),
        .issue_go_o(issue_go_o), .issue_accum_o(issue_accum_o), .wait_go_o(wait_go_o),
        .out_cnt_o(out_cnt_o), .rel_valid_o(rel_valid_o), .rel_slot_o(rel_slot_o),
        .ovf_err_o(ovf_err_o), .proto_err_o(proto_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: every release pulse is popped from the scoreboard and compared.
    always @(negedge clk) begin
        if (rst_n && rel_valid_o) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R4: actual release of slot %0d expected none", rel_slot_o);
            end else begin
                chk("R4 release slot", int'(rel_slot_o), exp_q.pop_front());
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
        fence_i = 0; issue_i = 0; commit_i = 0; wait_i = 0; done_i = 0;
    endtask

    task automatic open_grp();
        fence_i = 1; tick();
    endtask

    task automatic do_issue(input int exp_acc, input string req);
        issue_i = 1;
        @(negedge clk);
        chk({req, " issue accepted"}, int'(issue_go_o), 1);
        chk({req, " accumulate flag"}, int'(issue_accum_o), exp_acc);
        tick();
    endtask

    task automatic do_commit();
        commit_i = 1; tick();
    endtask

    task automatic do_done();
        done_i = 1; tick();
    endtask

    task automatic do_wait(input int thr, input int exp_go, input string req);
        wait_i = 1; wait_thr_i = OW'(thr);
        @(negedge clk);
        chk(req, int'(wait_go_o), exp_go);
        tick();
    endtask

    initial begin
        #800000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 count", int'(out_cnt_o), 0);
        chk("R10 release", int'(rel_valid_o), 0);
        chk("R10 overflow flag", int'(ovf_err_o), 0);
        chk("R10 protocol flag", int'(proto_err_o), 0);
        chk("R10 issue", int'(issue_go_o), 0);
        tick();
        do_wait(0, 1, "R3 empty wait grant");

        // Staggered loop, 6 iterations wrap the 4-slot ring (R5, R11)
        for (int k = 0; k < 6; k++) begin
            open_grp();
            do_issue((k == 0) ? 0 : 1, "R7");
            do_issue(1, "R7");
            do_commit();
            @(negedge clk);
            chk("R2 count after commit", int'(out_cnt_o), (k == 0) ? 1 : 2);
            tick();
            if (k > 0) begin
                do_wait(1, 0, "R3 stall above threshold");
                do_done();
                @(negedge clk);
                chk("R2 count after completion", int'(out_cnt_o), 1);
                tick();
                exp_q.push_back((k - 1) % STAGES);
                do_wait(1, 1, "R5 staggered wait grant");
                @(negedge clk);
                chk("R5 release pulse after grant", int'(rel_valid_o), 1);
                tick();
                @(negedge clk);
                chk("R4 single-cycle pulse", int'(rel_valid_o), 0);
                tick();
            end else begin
                do_wait(1, 1, "R5 first wait grant");
                @(negedge clk);
                chk("R5 no release after first wait", int'(rel_valid_o), 0);
                tick();
            end
        end
        // Drain the last group (R6)
        do_wait(0, 0, "R6 drain stalls");
        do_done();
        exp_q.push_back(5 % STAGES);
        do_wait(0, 1, "R6 drain grant");
        tick();
        tick();
        chk("R6 scoreboard empty", exp_q.size(), 0);

        // Three groups, then drain: releases in order on consecutive cycles (R6, R11)
        for (int g = 0; g < 3; g++) begin
            open_grp();
            do_issue((g == 0) ? 0 : 1, "R7 after drain");
            do_commit();
        end
        for (int g = 0; g < 3; g++) do_done();
        chk("R2 count drained", int'(out_cnt_o), 0);
        exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(0);
        do_wait(0, 1, "R6 drain grant");
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R6 consecutive release", int'(rel_valid_o), 1);
            tick();
        end
        @(negedge clk);
        chk("R6 release burst ends", int'(rel_valid_o), 0);
        chk("R6 scoreboard empty", exp_q.size(), 0);
        chk("R9 no protocol error yet", int'(proto_err_o), 0);
        tick();

        // Protocol misuse (R1, R9)
        issue_i = 1;
        @(negedge clk);
        chk("R1 issue refused while closed", int'(issue_go_o), 0);
        tick();
        @(negedge clk);
        chk("R9 protocol flag", int'(proto_err_o), 1);
        tick();
        do_done();
        @(negedge clk);
        chk("R9 spurious completion ignored", int'(out_cnt_o), 0);
        tick();

        // Saturation (R8)
        for (int g = 0; g < 15; g++) begin
            open_grp();
            do_commit();
        end
        @(negedge clk);
        chk("R8 count at maximum", int'(out_cnt_o), 15);
        chk("R8 no overflow yet", int'(ovf_err_o), 0);
        tick();
        open_grp();
        do_commit();
        @(negedge clk);
        chk("R8 count saturated", int'(out_cnt_o), 15);
        chk("R8 overflow flag", int'(ovf_err_o), 1);
        chk("R4 no stray releases", exp_q.size(), 0);
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule